// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Byte Error Tags

This block recovers asynchronous serial characters from a single input line. A clock enable pulsing at sixteen times the bit rate paces a small state machine, which qualifies the start bit at its midpoint. It then collects five to eight data bits, least significant first, plus an optional parity bit and the stop bit. The data word and three status tags (parity error, framing error, line break) are written together into a sixteen-deep first-in first-out store, so software learns exactly which byte was damaged.

On the host side, the oldest entry is always visible at the outputs, and a one-cycle pop advances past it. The host can also see the fill count, a data-ready flag, a fill-threshold flag and a sticky overrun flag, which a status-read strobe clears. An idle timer raises a timeout flag when bytes have sat unread and no new character has arrived for four character times plus twelve bit times. This lets a driver collect a short tail of data that never reaches the threshold. Frame format and threshold are static configuration inputs.

Top module: `serial_rx_tagged`

## Requirements
- R1: A falling line is confirmed as a start bit only if it still reads low on the 8th tick after the fall; if it reads high there, the receiver returns to idle and stores nothing.
- R2: `cfg_len` selects the data width as 5 + `cfg_len` bits (00 = 5 bits ... 11 = 8 bits). Bits arrive least significant first and are sampled every 16 ticks after the start midpoint. Unused upper bits of the stored byte are zero.
- R3: `cfg_par` selects parity: 01 odd, 10 even, 00 or 11 none. With parity on, the entry's parity tag is set when the ones count over data plus parity bit is wrong for the selected mode.
- R4: A low first stop bit sets the framing tag of that entry. After any low stop bit, the receiver does not look for a new start until the line has returned high.
- R5: When data, parity (if enabled) and stop bits all sample low, exactly one entry is stored with data 0, break tag 1, framing tag 1 and parity tag 0, however long the line stays low.
- R6: The store holds 16 entries in arrival order. The head entry is shown on `rd_*`, and `pop` removes it. A pop while empty has no effect.
- R7: A character completing while the store is full and not being popped is discarded and sets `overrun`. `overrun` stays set until `stat_rd` is pulsed.
- R8: `trig_hit` is high while the fill count is at least the level chosen by `cfg_trig` (00 = 1, 01 = 4, 10 = 8, 11 = 14).
- R9: `timeout` rises once the store is non-empty and no push or pop has occurred for 64*B + 192 ticks. B is the frame length in bits: 1 start + data + parity + 1 or 2 stop (`cfg_stop2` = 1 selects 2). Any push or pop clears it.
- R10: After reset the fill count is 0 and `data_ready`, `overrun`, `trig_hit` and `timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Data width select |
| cfg_par | input | 2 | Parity mode select |
| cfg_stop2 | input | 1 | Two stop bits (timing of timeout only) |
| cfg_trig | input | 2 | Fill threshold select |
| pop | input | 1 | Remove head entry |
| stat_rd | input | 1 | Status read strobe, clears overrun |
| rd_data | output | 8 | Head entry data |
| rd_pe | output | 1 | Head entry parity tag |
| rd_fe | output | 1 | Head entry framing tag |
| rd_brk | output | 1 | Head entry break tag |
| data_ready | output | 1 | Store non-empty |
| fill | output | $clog2(DEPTH)+1 | Entry count |
| trig_hit | output | 1 | Fill at or above threshold |
| timeout | output | 1 | Unread data idle too long |
| overrun | output | 1 | Sticky lost-character flag |

## Verification
The bench sends a short low pulse to confirm that a design sampling the start bit early, or not re-checking it, would store a phantom byte. It holds the line low for forty bit times, which exposes a receiver that re-arms on a low stop bit and floods the store with break entries. It overfills the store with seventeen characters to catch a design that overwrites the oldest entry or loses the sticky flag. It also probes the timeout a few dozen ticks either side of its threshold, so that a wrong bit count per frame or a timer that ignores pops shows up as an early or late flag.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_ODD   = 2'b01,
        PAR_EVEN  = 2'b10,
        PAR_NONE2 = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       pe;
        logic       fe;
        logic       brk;
    } rx_entry_t;

    function automatic logic [3:0] data_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    function automatic logic par_enabled(input logic [1:0] par);
        return (par == PAR_ODD) || (par == PAR_EVEN);
    endfunction

    function automatic logic [3:0] frame_bits(input logic [1:0] len,
                                              input logic [1:0] par,
                                              input logic       stop2);
        return 4'd2 + data_bits(len) + {3'b000, par_enabled(par)} + {3'b000, stop2};
    endfunction

    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/serial_rx_deser.sv
module serial_rx_deser
    import serial_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    output logic       push,
    output rx_entry_t  entry
);

    logic line;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign line = rxd;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sq;
            always_ff @(posedge clk) begin
                if (rst) sq <= '1;
                else     sq <= {sq[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], rxd} >> 0;
            end
            assign line = sq[SYNC_STAGES-1];
        end
    endgenerate

    rx_state_e  state;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] dbuf;
    logic       all_low;
    logic       pbit;
    logic [3:0] nbits;
    logic       par_en;
    logic       odd;
    logic       brk_now;

    assign nbits   = data_bits(cfg_len);
    assign par_en  = par_enabled(cfg_par);
    assign odd     = (cfg_par == PAR_ODD);
    assign brk_now = all_low && !line;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            dbuf    <= '0;
            all_low <= 1'b0;
            pbit    <= 1'b0;
            push    <= 1'b0;
            entry   <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            tcnt  <= '0;
                        end
                    end
                    ST_START: begin
                        if (tcnt == 4'd7) begin
                            tcnt    <= '0;
                            bidx    <= '0;
                            dbuf    <= '0;
                            all_low <= 1'b1;
                            state   <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            tcnt <= tcnt + 4'd1;
                        end
                    end
                    ST_DATA: begin
                        if (tcnt == 4'd15) begin
                            tcnt       <= '0;
                            dbuf[bidx] <= line;
                            all_low    <= all_low && !line;
                            if ({1'b0, bidx} == nbits - 4'd1)
                                state <= par_en ? ST_PAR : ST_STOP;
                            else
                                bidx <= bidx + 3'd1;
                        end else begin
                            tcnt <= tcnt + 4'd1;
                        end
                    end
                    ST_PAR: begin
                        if (tcnt == 4'd15) begin
                            tcnt    <= '0;
                            pbit    <= line;
                            all_low <= all_low && !line;
                            state   <= ST_STOP;
                        end else begin
                            tcnt <= tcnt + 4'd1;
                        end
                    end
                    ST_STOP: begin
                        if (tcnt == 4'd15) begin
                            tcnt       <= '0;
                            push       <= 1'b1;
                            entry.data <= brk_now ? 8'h00 : dbuf;
                            entry.fe   <= !line;
                            entry.brk  <= brk_now;
                            entry.pe   <= par_en && !brk_now && ((^dbuf) ^ pbit ^ odd);
                            state      <= line ? ST_IDLE : ST_WAIT_HIGH;
                        end else begin
                            tcnt <= tcnt + 4'd1;
                        end
                    end
                    ST_WAIT_HIGH: begin
                        if (line) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R1: a start that reads high at its midpoint is dropped
    assert_glitch_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && state == ST_START && tcnt == 4'd7 && line) |=> (state == ST_IDLE && !push));

    // R5: a break entry always carries the framing tag and a zero byte
    assert_break_tags_R5: assert property (@(posedge clk) disable iff (rst)
        (push && entry.brk) |-> (entry.fe && entry.data == 8'h00 && !entry.pe));

    // R4: no new start is hunted while the line is still low after a low stop bit
    assert_wait_high_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_HIGH && !line) |=> (state == ST_WAIT_HIGH));

endmodule

// File: rtl/serial_rx_store.sv
module serial_rx_store
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  rx_entry_t                wr_entry,
    input  logic                     pop,
    input  logic                     ovr_clr,
    output rx_entry_t                head,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     ovr
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          full;
    logic          empty;
    logic          do_pop;
    logic          do_push;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovr   <= 1'b0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && !do_push) ovr <= 1'b1;
            else if (ovr_clr)     ovr <= 1'b0;
        end
    end

    // R6: fill never exceeds the depth
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R6: pop on an empty store leaves it empty
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0));

    // R7: a character arriving when full is dropped and flagged
    assert_drop_full_R7: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == CW'(DEPTH) && ovr));

endmodule

// File: rtl/serial_rx_idle_timer.sv
module serial_rx_idle_timer #(
    parameter int CW = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       activity,
    input  logic       nonempty,
    input  logic [3:0] fbits,
    output logic       timeout
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] thr;

    assign thr     = {{(CW-10){1'b0}}, fbits, 6'b000000} + CW'(192);
    assign timeout = nonempty && (cnt >= thr);

    always_ff @(posedge clk) begin
        if (rst || activity || !nonempty) cnt <= '0;
        else if (tick && cnt < thr)       cnt <= cnt + 1'b1;
    end

    // R9: any push or pop silences the timeout on the next cycle
    assert_quiet_after_activity_R9: assert property (@(posedge clk) disable iff (rst)
        activity |=> !timeout);

endmodule

// File: rtl/serial_rx_tagged.sv
module serial_rx_tagged
    import serial_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int TMO_W       = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick16,
    input  logic                   rxd,
    input  logic [1:0]             cfg_len,
    input  logic [1:0]             cfg_par,
    input  logic                   cfg_stop2,
    input  logic [1:0]             cfg_trig,
    input  logic                   pop,
    input  logic                   stat_rd,
    output logic [7:0]             rd_data,
    output logic                   rd_pe,
    output logic                   rd_fe,
    output logic                   rd_brk,
    output logic                   data_ready,
    output logic [$clog2(DEPTH):0] fill,
    output logic                   trig_hit,
    output logic                   timeout,
    output logic                   overrun
);

    localparam int FW = $clog2(DEPTH) + 1;

    logic      push;
    rx_entry_t new_entry;
    rx_entry_t head;

    serial_rx_deser #(.SYNC_STAGES(SYNC_STAGES)) u_deser (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .rxd     (rxd),
        .cfg_len (cfg_len),
        .cfg_par (cfg_par),
        .push    (push),
        .entry   (new_entry)
    );

    serial_rx_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .wr_entry (new_entry),
        .pop      (pop),
        .ovr_clr  (stat_rd),
        .head     (head),
        .count    (fill),
        .ovr      (overrun)
    );

    serial_rx_idle_timer #(.CW(TMO_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .activity (push || (pop && data_ready)),
        .nonempty (data_ready),
        .fbits    (frame_bits(cfg_len, cfg_par, cfg_stop2)),
        .timeout  (timeout)
    );

    assign data_ready = (fill != '0);
    assign trig_hit   = (fill >= FW'(trig_level(cfg_trig)));
    assign rd_data    = head.data;
    assign rd_pe      = head.pe;
    assign rd_fe      = head.fe;
    assign rd_brk     = head.brk;

    // R10: reset leaves the store empty and all flags low
    assert_reset_state_R10: assert property (@(posedge clk)
        $past(rst) |-> (fill == '0 && !overrun && !timeout));

endmodule

// File: tb/serial_rx_tagged_tb.sv
module serial_rx_tagged_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_stop2 = 1'b0;
    logic [1:0] cfg_trig = 2'b00;
    logic       pop = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_pe, rd_fe, rd_brk, data_ready, trig_hit, timeout, overrun;
    logic [4:0] fill;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [10:0] expq[$];

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (rst) tick16 <= 1'b0;
        else     tick16 <= ~tick16;
    end

    serial_rx_tagged u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .cfg_trig(cfg_trig),
        .pop(pop), .stat_rd(stat_rd), .rd_data(rd_data), .rd_pe(rd_pe), .rd_fe(rd_fe),
        .rd_brk(rd_brk), .data_ready(data_ready), .fill(fill), .trig_hit(trig_hit),
        .timeout(timeout), .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (tick16 !== 1'b1) @(posedge clk);
        end
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk);
        rxd = v;
        wait_ticks(16);
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] len);
        return 8'hFF >> (3 - len);
    endfunction

    // Sends one frame and queues the expected entry {data, pe, fe, brk}
    task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic stop_low);
        logic [7:0] m;
        logic       par_on;
        logic       pb;
        logic       brk;
        m      = d & mask_of(cfg_len);
        par_on = (cfg_par == 2'b01) || (cfg_par == 2'b10);
        pb     = (cfg_par == 2'b10) ? ^m : ~(^m);
        pb     = pb ^ bad_par;
        brk    = stop_low && (m == 8'h00) && (!par_on || !pb);
        send_bit(1'b0);
        for (int i = 0; i < 5 + cfg_len; i++) send_bit(m[i]);
        if (par_on) send_bit(pb);
        send_bit(!stop_low);
        if (stop_low) send_bit(1'b1);
        else if (cfg_stop2) send_bit(1'b1);
        expq.push_back({brk ? 8'h00 : m, par_on && bad_par && !brk, stop_low, brk});
    endtask

    task automatic pop_check(input string req);
        logic [10:0] e;
        e = expq.pop_front();
        @(negedge clk);
        chk({req, " data_ready"}, data_ready, 1);
        chk({req, " data"}, rd_data, e[10:3]);
        chk({req, " pe"}, rd_pe, e[2]);
        chk({req, " fe"}, rd_fe, e[1]);
        chk({req, " brk"}, rd_brk, e[0]);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 fill", fill, 0);
        chk("R10 data_ready", data_ready, 0);
        chk("R10 overrun", overrun, 0);
        chk("R10 timeout", timeout, 0);
        chk("R10 trig_hit", trig_hit, 0);

        // R1 short low pulse is a glitch
        rxd = 1'b0;
        wait_ticks(4);
        @(negedge clk);
        rxd = 1'b1;
        wait_ticks(40);
        @(negedge clk);
        chk("R1 glitch stores nothing", fill, 0);

        // R6 pop on empty has no effect
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
        chk("R6 empty pop fill", fill, 0);
        send_frame(8'hA5, 1'b0, 1'b0);
        @(negedge clk);
        chk("R6 fill after one frame", fill, 1);
        pop_check("R2 8-bit frame");

        // R3 parity error tag, odd and even
        cfg_par = 2'b01;
        send_frame(8'h3C, 1'b1, 1'b0);
        cfg_par = 2'b10;
        send_frame(8'h81, 1'b1, 1'b0);
        send_frame(8'h81, 1'b0, 1'b0);
        pop_check("R3 odd bad");
        pop_check("R3 even bad");
        pop_check("R3 even good");

        // R4 framing error with nonzero data
        cfg_par = 2'b00;
        send_frame(8'h55, 1'b0, 1'b1);
        @(negedge clk);
        chk("R4 one entry", fill, 1);
        pop_check("R4 framing");

        // R5 long break gives exactly one entry
        @(negedge clk);
        rxd = 1'b0;
        wait_ticks(16 * 40);
        @(negedge clk);
        rxd = 1'b1;
        wait_ticks(32);
        @(negedge clk);
        chk("R5 single break entry", fill, 1);
        expq.push_back({8'h00, 1'b0, 1'b1, 1'b1});
        pop_check("R5 break");

        // R8 threshold 4
        cfg_trig = 2'b01;
        for (int i = 0; i < 3; i++) send_frame(8'(i + 1), 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 below threshold", trig_hit, 0);
        send_frame(8'h44, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 at threshold", trig_hit, 1);
        cfg_trig = 2'b11;
        @(negedge clk);
        chk("R8 level 14 not reached", trig_hit, 0);
        for (int i = 0; i < 4; i++) pop_check("R8 drain");

        // R9 timeout: 8N1, B=10, threshold 832 ticks
        cfg_trig = 2'b00;
        send_frame(8'h77, 1'b0, 1'b0);
        send_frame(8'h78, 1'b0, 1'b0);
        wait_ticks(790);
        @(negedge clk);
        chk("R9 not yet", timeout, 0);
        wait_ticks(70);
        @(negedge clk);
        chk("R9 fired", timeout, 1);
        pop_check("R9 pop");
        @(negedge clk);
        chk("R9 cleared by pop", timeout, 0);
        wait_ticks(780);
        @(negedge clk);
        chk("R9 restarted by pop", timeout, 0);
        wait_ticks(80);
        @(negedge clk);
        chk("R9 fired again", timeout, 1);
        pop_check("R9 drain");
        @(negedge clk);
        chk("R9 low when empty", timeout, 0);

        // R7 overrun on 17th frame
        for (int i = 0; i < 17; i++) send_frame(8'($urandom), 1'b0, 1'b0);
        void'(expq.pop_back());
        @(negedge clk);
        chk("R7 fill full", fill, 16);
        chk("R7 overrun set", overrun, 1);
        wait_ticks(20);
        @(negedge clk);
        chk("R7 overrun sticky", overrun, 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R7 overrun cleared", overrun, 0);
        for (int i = 0; i < 16; i++) pop_check("R7 kept order");

        // R2 R3 R6 random formats
        for (int b = 0; b < 6; b++) begin
            cfg_len   = 2'($urandom);
            cfg_par   = 2'($urandom);
            cfg_stop2 = 1'($urandom);
            for (int i = 0; i < 8; i++)
                send_frame(8'($urandom) | 8'h01, 1'($urandom), 1'b0);
            @(negedge clk);
            chk("R6 random fill", fill, 8);
            for (int i = 0; i < 8; i++) pop_check("R2 R3 random");
        end
        @(negedge clk);
        chk("R6 drained", fill, 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule